// File: doc/BRIEF.md
# Scatter-Gather DMA Address Translator

This block turns an I/O bus address into a host memory address for a single window that has already been matched and that works in scatter-gather mode. It is given the bus address and the window's mask and translated-base register values. From these it forms the address of a page-table entry in host memory. It fetches that 64-bit entry through a read port, then joins the entry's page frame with the page offset taken from the bus address.

Translations enter through a valid/ready handshake and leave through a second valid/ready handshake. Only one translation is in flight at a time. The entry fetch is a request that stays asserted until memory accepts it, followed by a single-beat data return. The entry's bit 0 marks it as valid. A fetched entry with bit 0 clear gives an error response in place of an address.

Top module: `sg_xlate_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `mem_rd_valid` is 0 and `rsp_valid` is 0.
- R2: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its response is accepted. A request presented in the same cycle as that response handshake is taken one cycle later.
- R3: The cycle after a request is accepted, `mem_rd_valid` is 1 and `mem_rd_addr` carries the entry address, built from low to high as follows. Bits 2:0 are base[2:0]. Bits 9:3 are bus[19:13]. For i = 10..21, bit i is bus[i+10] when mask[i+10] is 1, and base[i] otherwise. Bits 33:22 are base[33:22].
- R4: `mem_rd_valid` and `mem_rd_addr` do not change while `mem_rd_ready` is 0. `mem_rd_valid` falls in the cycle after `mem_rd_ready` is seen high.
- R5: `mem_rd_data` is captured only when `mem_rd_data_valid` is 1 after the read request has been accepted. Data returned with `mem_rd_data_valid` high at any other time has no effect on the response.
- R6: The cycle after the entry is captured, `rsp_valid` is 1. When entry bit 0 is 1, `rsp_err` is 0 and `rsp_addr` = {entry[21:1], bus[12:0]}.
- R7: When entry bit 0 is 0, `rsp_err` is 1 and `rsp_addr` is 0.
- R8: `rsp_valid`, `rsp_addr` and `rsp_err` hold while `rsp_ready` is 0. `rsp_valid` falls in the cycle after the response handshake.
- R9: Output addresses are 34 bits wide. Entry bits above 21 and base bits above 33 never reach any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_bus_addr | input | 32 | I/O bus address to translate |
| req_win_mask | input | 64 | Matched window's mask register value |
| req_tbase | input | 64 | Matched window's translated-base register value |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 34 | Entry address in host memory |
| mem_rd_data_valid | input | 1 | Entry data returned |
| mem_rd_data | input | 64 | Returned page-table entry |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 34 | Host DMA address |
| rsp_err | output | 1 | Entry was not valid |

## Verification
Two events can fall in one cycle: the consumer accepts a finished response, and a new translation request arrives. The bench provokes this by raising `rsp_ready` and `req_valid` at the same time. It then judges that `req_ready` stays low in that cycle and rises one cycle later. It also checks that the second request then yields its own entry address and result. Stray memory data sent while the read request is still stalled also checks that capture happens only in the wait phase.

// File: rtl/sg_xlate_pkg.sv
package sg_xlate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_MWAIT = 2'd2,
    ST_RESP  = 2'd3
  } sg_state_e;

  // window mask bits that select bus-address bits into the entry index
  localparam logic [63:0] SG_WIN_FIELD = 64'h0000_0000_FFF0_0000;
  // bus-address bits always used as entry index
  localparam logic [63:0] SG_FIX_FIELD = 64'h0000_0000_000F_E000;
  // right shift from bus-address index to entry byte address
  localparam int unsigned SG_IDX_SHIFT = 10;
  // page shift applied to the entry's frame bits
  localparam int unsigned SG_PG_SHIFT  = 12;
  // width of the in-page offset copied from the bus address
  localparam int unsigned SG_OFS_W     = 13;

endpackage

// File: rtl/sg_pte_addr.sv
module sg_pte_addr
  import sg_xlate_pkg::*;
#(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned REG_W = 64,
  parameter int unsigned DMA_W = 34
) (
  input  logic [BUS_W-1:0] bus_addr,
  input  logic [REG_W-1:0] win_mask,
  input  logic [REG_W-1:0] tbase,
  output logic [DMA_W-1:0] pte_addr
);

  logic [REG_W-1:0] bus_ext;
  logic [REG_W-1:0] ba_mask;
  logic [REG_W-1:0] tb_mask;
  logic [REG_W-1:0] idx_part;
  logic [REG_W-1:0] pte_full;
  logic             unused_hi;

  always_comb begin
    bus_ext  = REG_W'(bus_addr);
    ba_mask  = (win_mask & REG_W'(SG_WIN_FIELD)) | REG_W'(SG_FIX_FIELD);
    tb_mask  = (~ba_mask) >> SG_IDX_SHIFT;
    idx_part = (bus_ext & ba_mask) >> SG_IDX_SHIFT;
    pte_full = (tbase & tb_mask) | idx_part;
  end

  assign pte_addr  = pte_full[DMA_W-1:0];
  assign unused_hi = ^pte_full[REG_W-1:DMA_W];

endmodule

// File: rtl/sg_dma_form.sv
module sg_dma_form
  import sg_xlate_pkg::*;
#(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned REG_W = 64,
  parameter int unsigned DMA_W = 34
) (
  input  logic [BUS_W-1:0] bus_addr,
  input  logic [REG_W-1:0] entry,
  output logic [DMA_W-1:0] dma_addr,
  output logic             entry_bad
);

  localparam int unsigned FRAME_W = DMA_W - SG_OFS_W;

  logic [FRAME_W-1:0] frame;
  logic [SG_OFS_W-1:0] ofs;
  logic               unused_bits;

  // entry bit 0 is the valid flag; frame bits start at bit 1
  assign frame     = entry[FRAME_W:1];
  assign ofs       = bus_addr[SG_OFS_W-1:0];
  assign entry_bad = ~entry[0];
  assign dma_addr  = entry_bad ? '0 : {frame, ofs};

  assign unused_bits = ^{entry[REG_W-1:FRAME_W+1], bus_addr[BUS_W-1:SG_OFS_W]};

endmodule

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import sg_xlate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_rd_ready,
  input  logic mem_rd_data_valid,
  input  logic rsp_ready,
  output logic req_ready,
  output logic mem_rd_valid,
  output logic rsp_valid,
  output logic ld_req,
  output logic ld_entry
);

  sg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid)         state_d = ST_MREQ;
      ST_MREQ:  if (mem_rd_ready)      state_d = ST_MWAIT;
      ST_MWAIT: if (mem_rd_data_valid) state_d = ST_RESP;
      ST_RESP:  if (rsp_ready)         state_d = ST_IDLE;
      default:                         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_MREQ);
  assign rsp_valid    = (state_q == ST_RESP);
  assign ld_req       = req_ready && req_valid;
  assign ld_entry     = (state_q == ST_MWAIT) && mem_rd_data_valid;

endmodule

// File: rtl/sg_xlate_top.sv
module sg_xlate_top
  import sg_xlate_pkg::*;
#(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned REG_W = 64,
  parameter int unsigned DMA_W = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BUS_W-1:0] req_bus_addr,
  input  logic [REG_W-1:0] req_win_mask,
  input  logic [REG_W-1:0] req_tbase,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [DMA_W-1:0] mem_rd_addr,
  input  logic             mem_rd_data_valid,
  input  logic [REG_W-1:0] mem_rd_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DMA_W-1:0] rsp_addr,
  output logic             rsp_err
);

  logic             ld_req;
  logic             ld_entry;
  logic [DMA_W-1:0] pte_addr_d;
  logic [DMA_W-1:0] pte_addr_q;
  logic [BUS_W-1:0] bus_q;
  logic [REG_W-1:0] entry_q;

  sg_ctrl i_ctrl (
    .clk               (clk),
    .rst_n             (rst_n),
    .req_valid         (req_valid),
    .mem_rd_ready      (mem_rd_ready),
    .mem_rd_data_valid (mem_rd_data_valid),
    .rsp_ready         (rsp_ready),
    .req_ready         (req_ready),
    .mem_rd_valid      (mem_rd_valid),
    .rsp_valid         (rsp_valid),
    .ld_req            (ld_req),
    .ld_entry          (ld_entry)
  );

  sg_pte_addr #(.BUS_W(BUS_W), .REG_W(REG_W), .DMA_W(DMA_W)) i_pte (
    .bus_addr (req_bus_addr),
    .win_mask (req_win_mask),
    .tbase    (req_tbase),
    .pte_addr (pte_addr_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pte_addr_q <= '0;
      bus_q      <= '0;
    end else if (ld_req) begin
      pte_addr_q <= pte_addr_d;
      bus_q      <= req_bus_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        entry_q <= '0;
    else if (ld_entry) entry_q <= mem_rd_data;
  end

  sg_dma_form #(.BUS_W(BUS_W), .REG_W(REG_W), .DMA_W(DMA_W)) i_form (
    .bus_addr  (bus_q),
    .entry     (entry_q),
    .dma_addr  (rsp_addr),
    .entry_bad (rsp_err)
  );

  assign mem_rd_addr = pte_addr_q;

endmodule

// File: rtl/sg_xlate_chk.sv
module sg_xlate_chk #(
  parameter int unsigned DMA_W = 34
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_rd_valid,
  input logic             mem_rd_ready,
  input logic [DMA_W-1:0] mem_rd_addr,
  input logic             mem_rd_data_valid,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [DMA_W-1:0] rsp_addr,
  input logic             rsp_err
);

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (mem_rd_valid || rsp_valid))); // R2

  AST_ACCEPT_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_rd_valid && !req_ready)); // R3

  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R4

  AST_MREQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid); // R4

  AST_RSP_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(mem_rd_data_valid)); // R5

  AST_ERR_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_addr == '0)); // R7

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_err))); // R8

endmodule

bind sg_xlate_top sg_xlate_chk #(.DMA_W(DMA_W)) i_sg_xlate_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .req_valid         (req_valid),
  .req_ready         (req_ready),
  .mem_rd_valid      (mem_rd_valid),
  .mem_rd_ready      (mem_rd_ready),
  .mem_rd_addr       (mem_rd_addr),
  .mem_rd_data_valid (mem_rd_data_valid),
  .rsp_valid         (rsp_valid),
  .rsp_ready         (rsp_ready),
  .rsp_addr          (rsp_addr),
  .rsp_err           (rsp_err)
);

// File: tb/test_sg_xlate_top.sv
`timescale 1ns/1ps
module test_sg_xlate_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_bus_addr;
  logic [63:0] req_win_mask;
  logic [63:0] req_tbase;
  logic        mem_rd_valid;
  logic        mem_rd_ready;
  logic [33:0] mem_rd_addr;
  logic        mem_rd_data_valid;
  logic [63:0] mem_rd_data;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [33:0] rsp_addr;
  logic        rsp_err;

  int n_checks = 0;
  int n_errs   = 0;

  always #4 clk = ~clk;

  sg_xlate_top i_sg_xlate_top (.*);

  typedef struct packed {
    logic [31:0] bus;
    logic [63:0] mask;
    logic [63:0] tba;
    logic [63:0] pte;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1234_5678, 64'h0000_0000_FFF0_0000, 64'h0000_0003_C000_0000, 64'h0000_0000_0012_3457},
    '{32'hFFFF_FFFF, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    '{32'h0000_1FFF, 64'h0000_0000_00F0_0000, 64'h0000_0001_2345_6000, 64'h0000_0000_0000_0ABC},
    '{32'h8001_E008, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0002_AAAA_AAA8, 64'h0000_0000_003F_FFFF},
    '{32'hA5A5_A5A5, 64'h0000_0000_5550_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // entry address per R3, built field by field
  function automatic logic [33:0] exp_pte(input logic [31:0] b, input logic [63:0] m, input logic [63:0] t);
    logic [33:0] r;
    r[33:22] = t[33:22];
    for (int i = 10; i <= 21; i++) r[i] = m[i+10] ? b[i+10] : t[i];
    r[9:3] = b[19:13];
    r[2:0] = t[2:0];
    return r;
  endfunction

  function automatic logic [33:0] exp_dma(input logic [31:0] b, input logic [63:0] e);
    return e[0] ? {e[21:1], b[12:0]} : 34'd0;
  endfunction

  task automatic issue(input vec_t v);
    req_bus_addr = v.bus;
    req_win_mask = v.mask;
    req_tbase    = v.tba;
    req_valid    = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid    = 1'b0;
    req_bus_addr = 32'hDEAD_BEEF;
    req_win_mask = '1;
    req_tbase    = '1;
  endtask

  task automatic serve(input logic [33:0] ea, input int stall, input int lat, input logic [63:0] pte);
    for (int k = 0; k < stall; k++) begin
      chk(mem_rd_valid && mem_rd_addr == ea, "R3/R4 read request held", {29'd0, mem_rd_valid, mem_rd_addr}, {29'd0, 1'b1, ea});
      chk(!req_ready, "R2 busy during read", 64'(req_ready), 64'd0);
      mem_rd_data_valid = 1'b1;
      mem_rd_data       = 64'hFFFF_0000_FFFF_FFFE; // stray data, R5
      @(negedge clk);
    end
    mem_rd_data_valid = 1'b0;
    chk(mem_rd_valid && mem_rd_addr == ea, "R3 read address", {29'd0, mem_rd_valid, mem_rd_addr}, {29'd0, 1'b1, ea});
    mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0;
    chk(!mem_rd_valid, "R4 request drops after acceptance", 64'(mem_rd_valid), 64'd0);
    for (int k = 0; k < lat; k++) begin
      chk(!rsp_valid, "R6 no response before data", 64'(rsp_valid), 64'd0);
      @(negedge clk);
    end
    mem_rd_data_valid = 1'b1;
    mem_rd_data       = pte;
    @(negedge clk);
    mem_rd_data_valid = 1'b0;
    mem_rd_data       = 64'h0123_4567_89AB_CDEF;
  endtask

  task automatic take(input logic [33:0] ea, input bit eerr, input int hold);
    chk(rsp_valid, "R6 response valid after data", 64'(rsp_valid), 64'd1);
    chk(rsp_addr == ea && rsp_err == eerr, "R5/R6/R7/R9 result",
        {29'd0, rsp_err, rsp_addr}, {29'd0, eerr, ea});
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_addr == ea && rsp_err == eerr, "R8 response held",
          {29'd0, rsp_err, rsp_addr}, {29'd0, eerr, ea});
      chk(!req_ready, "R2 busy while response pending", 64'(req_ready), 64'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R8 response drops, R2 ready returns",
        {62'd0, rsp_valid, req_ready}, 64'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    vec_t a;
    vec_t b;
    rst_n = 1'b0;
    req_valid = 1'b0; req_bus_addr = '0; req_win_mask = '0; req_tbase = '0;
    mem_rd_ready = 1'b0; mem_rd_data_valid = 1'b0; mem_rd_data = '0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_rd_valid && !rsp_valid, "R1 reset state",
        {61'd0, req_ready, mem_rd_valid, rsp_valid}, 64'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_rd_valid && !rsp_valid, "R1 after reset release",
        {61'd0, req_ready, mem_rd_valid, rsp_valid}, 64'h4);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i]);
      serve(exp_pte(VECS[i].bus, VECS[i].mask, VECS[i].tba), i % 3, i % 2, VECS[i].pte);
      take(exp_dma(VECS[i].bus, VECS[i].pte), !VECS[i].pte[0], (i + 1) % 3);
    end

    // R2/R8 overlap: response handshake and new request in the same cycle
    a = VECS[0];
    b = VECS[3];
    issue(a);
    serve(exp_pte(a.bus, a.mask, a.tba), 0, 0, a.pte);
    chk(rsp_valid && rsp_addr == exp_dma(a.bus, a.pte), "R6 overlap first result",
        {30'd0, rsp_addr}, {30'd0, exp_dma(a.bus, a.pte)});
    req_bus_addr = b.bus; req_win_mask = b.mask; req_tbase = b.tba;
    req_valid = 1'b1;
    rsp_ready = 1'b1;
    chk(!req_ready, "R2 not ready in response-handshake cycle", 64'(req_ready), 64'd0);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready && !rsp_valid, "R2 ready one cycle after handshake",
        {62'd0, req_ready, rsp_valid}, 64'h2);
    issue(b);
    serve(exp_pte(b.bus, b.mask, b.tba), 1, 2, b.pte);
    take(exp_dma(b.bus, b.pte), 1'b0, 0);

    // R5: data with valid high while idle has no effect on the next result
    mem_rd_data_valid = 1'b1;
    mem_rd_data = 64'h0000_0000_0000_0000;
    @(negedge clk);
    mem_rd_data_valid = 1'b0;
    chk(!rsp_valid && req_ready, "R5 idle data ignored", {62'd0, rsp_valid, req_ready}, 64'h1);
    issue(VECS[4]);
    serve(exp_pte(VECS[4].bus, VECS[4].mask, VECS[4].tba), 0, 1, VECS[4].pte);
    take(exp_dma(VECS[4].bus, VECS[4].pte), 1'b0, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule